// File: doc/BRIEF.md
# Single-Precision Special-Operand Resolver

This block is the first stage of a single-precision floating-point pipeline. It takes one operation per cycle: an operation code and two 32-bit operands. It looks at the operand bit patterns and settles every case that needs no rounding arithmetic. The three sign-and-move operations (copy, absolute value, negate) are finished here. Any add or multiply that has a NaN operand is also resolved here. That covers two outcomes: a write of the fixed default quiet NaN, or an invalid-operation exception with the destination write suppressed. An add or multiply with only ordinary operands is handed on to the arithmetic stage. It leaves with a "needs arithmetic" strobe and its operands, and denormal operands may first be flushed to signed zero.

The NaN convention is the reverse of the common one. An operand is a NaN when its exponent field is all ones and its fraction is non-zero. Within a NaN, fraction bit 22 set means signaling and bit 22 clear means quiet. The default quiet NaN written by the block is 32'h7FBF_FFFF. A sticky invalid-operation flag records every signaling-NaN event. A synchronous clear input resets the flag. All outputs are registered, one cycle after the input strobe.

Top module: `fp_special_stage`

## Requirements
- R1: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are non-zero. It is signaling when bit 22 is 1 and quiet when bit 22 is 0. All ones in the exponent with a zero fraction (infinity) is not a NaN.
- R2: If add (opcode 3'b011) or multiply (3'b100) has at least one signaling-NaN operand and invEn is 0, the output shows wrEn=1, result=32'h7FBF_FFFF, excStrobe=0 and needArith=0.
- R3: If add or multiply has at least one signaling-NaN operand and invEn is 1, the output shows excStrobe=1 with wrEn=0 and needArith=0.
- R4: If add or multiply has a quiet-NaN operand and no signaling NaN, the output shows wrEn=1 and result=32'h7FBF_FFFF. excStrobe is 0 whatever invEn is, and invSticky does not change.
- R5: For add or multiply with no NaN operand, an operand with bits 30:23 zero and bits 22:0 non-zero (a denormal) is forwarded on fwdA/fwdB as a zero of the same sign (bit 31 kept, all other bits 0) when flushEn is 1. When flushEn is 0 it is forwarded unchanged.
- R6: Copy (3'b000), absolute value (3'b001) and negate (3'b010) act on operand A. They give wrEn=1 with result equal to A, to A with bit 31 cleared, or to A with bit 31 inverted. They do this even for NaN and denormal inputs. They never raise excStrobe and never set invSticky.
- R7: Opcodes 3'b101 to 3'b111 give outValid=1 with wrEn, needArith and excStrobe all 0, and they leave invSticky unchanged, even with signaling-NaN operands.
- R8: invSticky becomes 1 after any add or multiply with a signaling-NaN operand, whatever invEn is. It stays 1 until a cycle with clrInv=1 and no new signaling event. If a new event and clrInv come in the same cycle, the event wins.
- R9: outValid, wrEn, needArith and excStrobe appear exactly one clock after the inValid cycle that caused them. They are all 0 after a clock where inValid was 0.
- R10: For add or multiply with no NaN operand, needArith=1 and wrEn=0 and excStrobe=0. fwdA and fwdB carry the (possibly flushed) operands. Infinity counts as an ordinary operand.
- R11: While rstN is low at a clock edge, every output including invSticky is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation code |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B (add and multiply only) |
| invEn | input | 1 | 1: signaling NaN raises an exception instead of writing |
| flushEn | input | 1 | 1: flush denormal operands of add and multiply to signed zero |
| clrInv | input | 1 | Synchronous clear of the sticky invalid flag |
| outValid | output | 1 | Registered valid, one cycle after inValid |
| wrEn | output | 1 | Destination write enable for result |
| result | output | 32 | Resolved result |
| needArith | output | 1 | Operation must go to the arithmetic stage |
| fwdA | output | 32 | Forwarded operand A (valid with needArith) |
| fwdB | output | 32 | Forwarded operand B (valid with needArith) |
| excStrobe | output | 1 | Invalid-operation exception, one cycle |
| invSticky | output | 1 | Sticky invalid-operation flag |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-cycle latency of the strobes and the rule that at most one of write, arithmetic and exception is raised. They also check that an exception never comes with a write or without invEn, that the sticky flag holds until cleared, and the bit-31-only effect of absolute value and negate. Other behaviour is shown only by the bench scenarios. That includes which NaN class leads to which outcome, the exact default NaN value and the boundary between NaN and infinity. It also covers the flush of denormal operands, the unused opcodes, and a clear that arrives together with a new event.

// File: rtl/fpsp_pkg.sv
package fpsp_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = WORD_W - 1 - EXP_W;
  localparam int OP_W   = 3;
  localparam int SIG_BIT = FRAC_W - 1;
  localparam logic [WORD_W-1:0] DEFAULT_QNAN = 32'h7FBF_FFFF;

  typedef enum logic [OP_W-1:0] {
    OP_COPY = 3'b000,
    OP_ABS  = 3'b001,
    OP_NEG  = 3'b010,
    OP_ADD  = 3'b011,
    OP_MUL  = 3'b100
  } opSel_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_PASS, SEL_ABS, SEL_NEG, SEL_QNAN
  } resSel_e;

  typedef struct packed {
    logic    valid;
    logic    wr;
    logic    arith;
    logic    exc;
    logic    setInv;
    resSel_e sel;
  } strobe_t;

  typedef struct packed {
    logic isNan;
    logic isSig;
  } nanClass_t;

  function automatic nanClass_t classifyMag(input logic [WORD_W-2:0] mag);
    nanClass_t c;
    c.isNan = (&mag[WORD_W-2:FRAC_W]) && (|mag[FRAC_W-1:0]);
    c.isSig = c.isNan && mag[SIG_BIT];
    return c;
  endfunction
endpackage

// File: rtl/fpsp_ctrl.sv
module fpsp_ctrl
  import fpsp_pkg::*;
(
  input  logic                inValid,
  input  logic [OP_W-1:0]     opCode,
  input  logic [WORD_W-2:0]   magA,
  input  logic [WORD_W-2:0]   magB,
  input  logic                invEn,
  output strobe_t             strb
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][WORD_W-2:0] mags;
  logic [N_OPS-1:0] nanVec;
  logic [N_OPS-1:0] sigVec;

  assign mags = {magB, magA};

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    nanClass_t cls;
    assign cls       = classifyMag(mags[i]);
    assign nanVec[i] = cls.isNan;
    assign sigVec[i] = cls.isSig;
  end

  logic anyNan;
  logic anySig;
  assign anyNan = |nanVec;
  assign anySig = |sigVec;

  always_comb begin
    strb = '0;
    strb.sel = SEL_ZERO;
    if (inValid) begin
      strb.valid = 1'b1;
      case (opSel_e'(opCode))
        OP_COPY: begin strb.wr = 1'b1; strb.sel = SEL_PASS; end
        OP_ABS:  begin strb.wr = 1'b1; strb.sel = SEL_ABS;  end
        OP_NEG:  begin strb.wr = 1'b1; strb.sel = SEL_NEG;  end
        OP_ADD, OP_MUL: begin
          if (anySig) begin
            strb.setInv = 1'b1;
            if (invEn) begin
              strb.exc = 1'b1;
            end else begin
              strb.wr  = 1'b1;
              strb.sel = SEL_QNAN;
            end
          end else if (anyNan) begin
            strb.wr  = 1'b1;
            strb.sel = SEL_QNAN;
          end else begin
            strb.arith = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpsp_dpath.sv
module fpsp_dpath
  import fpsp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              flushEn,
  input  logic              clrInv,
  output logic              outValid,
  output logic              wrEn,
  output logic [WORD_W-1:0] result,
  output logic              needArith,
  output logic [WORD_W-1:0] fwdA,
  output logic [WORD_W-1:0] fwdB,
  output logic              excStrobe,
  output logic              invSticky
);
  function automatic logic [WORD_W-1:0] flushOp(input logic [WORD_W-1:0] x, input logic en);
    logic isDen;
    isDen = (x[WORD_W-2:FRAC_W] == '0) && (|x[FRAC_W-1:0]);
    return (en && isDen) ? {x[WORD_W-1], {(WORD_W-1){1'b0}}} : x;
  endfunction

  logic [WORD_W-1:0] flA;
  logic [WORD_W-1:0] flB;
  logic [WORD_W-1:0] resNext;

  assign flA = flushOp(opA, flushEn);
  assign flB = flushOp(opB, flushEn);

  always_comb begin
    case (strb.sel)
      SEL_PASS: resNext = opA;
      SEL_ABS:  resNext = {1'b0, opA[WORD_W-2:0]};
      SEL_NEG:  resNext = {~opA[WORD_W-1], opA[WORD_W-2:0]};
      SEL_QNAN: resNext = DEFAULT_QNAN;
      default:  resNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      wrEn      <= 1'b0;
      needArith <= 1'b0;
      excStrobe <= 1'b0;
      result    <= '0;
      fwdA      <= '0;
      fwdB      <= '0;
      invSticky <= 1'b0;
    end else begin
      outValid  <= strb.valid;
      wrEn      <= strb.wr;
      needArith <= strb.arith;
      excStrobe <= strb.exc;
      if (strb.valid) begin
        result <= resNext;
        fwdA   <= strb.arith ? flA : '0;
        fwdB   <= strb.arith ? flB : '0;
      end
      if (strb.setInv)   invSticky <= 1'b1;
      else if (clrInv)   invSticky <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_special_stage.sv
module fp_special_stage
  import fpsp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              invEn,
  input  logic              flushEn,
  input  logic              clrInv,
  output logic              outValid,
  output logic              wrEn,
  output logic [WORD_W-1:0] result,
  output logic              needArith,
  output logic [WORD_W-1:0] fwdA,
  output logic [WORD_W-1:0] fwdB,
  output logic              excStrobe,
  output logic              invSticky
);
  strobe_t strb;

  fpsp_ctrl u_ctrl (
    .inValid (inValid),
    .opCode  (opCode),
    .magA    (opA[WORD_W-2:0]),
    .magB    (opB[WORD_W-2:0]),
    .invEn   (invEn),
    .strb    (strb)
  );

  fpsp_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .flushEn   (flushEn),
    .clrInv    (clrInv),
    .outValid  (outValid),
    .wrEn      (wrEn),
    .result    (result),
    .needArith (needArith),
    .fwdA      (fwdA),
    .fwdB      (fwdB),
    .excStrobe (excStrobe),
    .invSticky (invSticky)
  );
endmodule

// File: rtl/fpsp_chk.sv
module fpsp_chk
  import fpsp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opCode,
  input logic [WORD_W-1:0] opA,
  input logic              invEn,
  input logic              clrInv,
  input logic              outValid,
  input logic              wrEn,
  input logic [WORD_W-1:0] result,
  input logic              needArith,
  input logic              excStrobe,
  input logic              invSticky
);
  a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !wrEn && !needArith && !excStrobe));
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, needArith, excStrobe}));
  a_r3_exc_no_write: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |-> !wrEn);
  a_r3_exc_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !invEn |=> !excStrobe);
  a_r8_exc_marks_sticky: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |-> invSticky);
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    invSticky && !clrInv |=> invSticky);
  a_r6_abs_bit31: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opCode == OP_ABS |=> wrEn && result == {1'b0, $past(opA[WORD_W-2:0])});
  a_r6_neg_bit31: assert property (@(posedge clk) disable iff (!rstN)
    inValid && opCode == OP_NEG |=> wrEn && result == {~$past(opA[WORD_W-1]), $past(opA[WORD_W-2:0])});
  a_r11_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!outValid && !invSticky && !excStrobe));
endmodule

bind fp_special_stage fpsp_chk u_chk (.*);

// File: tb/sim_fp_special_stage.sv
`timescale 1ns/1ps
module sim_fp_special_stage;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic invEn = 1'b0, flushEn = 1'b0, clrInv = 1'b0;
  logic outValid, wrEn, needArith, excStrobe, invSticky;
  logic [31:0] result, fwdA, fwdB;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_special_stage u0 (.*);

  localparam logic [31:0] QN = 32'h7FBF_FFFF;

  typedef struct packed {
    logic [2:0]  op;
    logic        inv;
    logic        fl;
    logic [31:0] a;
    logic [31:0] b;
    logic        wr;
    logic        ar;
    logic        ex;
    logic        setS;
    logic [31:0] res;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 1'b1, 32'h7FC0_0001, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h7FC0_0001}, // R6 copy sNaN
    '{3'd1, 1'b1, 1'b1, 32'hFFC0_0001, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h7FC0_0001}, // R6 abs
    '{3'd2, 1'b0, 1'b1, 32'h0000_0005, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_0005}, // R6 neg no flush
    '{3'd3, 1'b0, 1'b0, 32'h7FC0_0000, 32'h3F80_0000, 1'b1, 1'b0, 1'b0, 1'b1, QN},    // R2
    '{3'd4, 1'b1, 1'b0, 32'h3F80_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0}, // R3
    '{3'd3, 1'b1, 1'b0, 32'h3F80_0000, 32'h7F80_0001, 1'b1, 1'b0, 1'b0, 1'b0, QN},    // R4 qNaN, invEn=1
    '{3'd3, 1'b0, 1'b0, 32'h7FA0_0000, 32'h7FC0_0000, 1'b1, 1'b0, 1'b0, 1'b1, QN},    // R1 q+s -> sNaN path
    '{3'd4, 1'b0, 1'b0, 32'h3F80_0000, 32'h4000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0}, // R10
    '{3'd3, 1'b1, 1'b0, 32'h7F80_0000, 32'h3F80_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0}, // R1 inf not NaN
    '{3'd5, 1'b0, 1'b0, 32'h3F80_0000, 32'h3F80_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0}, // R7
    '{3'd7, 1'b1, 1'b0, 32'h7FC0_0000, 32'h7FC0_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0}, // R7 sNaN ignored
    '{3'd4, 1'b0, 1'b0, 32'hFF80_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b0, QN}     // R4 qNaN mul
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic inv, input logic fl,
                       input logic [31:0] a, input logic [31:0] b, input logic clr);
    @(negedge clk);
    inValid = 1'b1; opCode = op; invEn = inv; flushEn = fl; opA = a; opB = b; clrInv = clr;
    @(negedge clk);
    inValid = 1'b0; clrInv = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic expS;
    expS = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 outValid", {31'b0, outValid}, 32'd0);
    chk("R11 invSticky", {31'b0, invSticky}, 32'd0);
    chk("R11 result", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R9 idle
    chk("R9 idle strobes", {28'b0, outValid, wrEn, needArith, excStrobe}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].inv, VECS[i].fl, VECS[i].a, VECS[i].b, 1'b0);
      expS = expS | VECS[i].setS;
      chk($sformatf("R9 outValid v%0d", i), {31'b0, outValid}, 32'd1);
      chk($sformatf("R2/R3/R4/R7/R10 strobes v%0d", i), {29'b0, wrEn, needArith, excStrobe},
          {29'b0, VECS[i].wr, VECS[i].ar, VECS[i].ex});
      if (VECS[i].wr) chk($sformatf("R6/R2/R4 result v%0d", i), result, VECS[i].res);
      chk($sformatf("R8 sticky v%0d", i), {31'b0, invSticky}, {31'b0, expS});
      @(negedge clk);
      chk($sformatf("R9 strobes drop v%0d", i), {28'b0, outValid, wrEn, needArith, excStrobe}, 32'd0);
    end

    // R5 flush on, sign kept
    issue(3'd3, 1'b0, 1'b1, 32'h8000_0005, 32'h0000_0003, 1'b0);
    chk("R5 flush fwdA", fwdA, 32'h8000_0000);
    chk("R5 flush fwdB", fwdB, 32'h0000_0000);
    chk("R10 needArith", {31'b0, needArith}, 32'd1);
    // R5 flush off
    issue(3'd4, 1'b0, 1'b0, 32'h8000_0005, 32'h0000_0003, 1'b0);
    chk("R5 pass fwdA", fwdA, 32'h8000_0005);
    chk("R5 pass fwdB", fwdB, 32'h0000_0003);
    // R5 normal operand untouched with flush on
    issue(3'd3, 1'b0, 1'b1, 32'h0080_0000, 32'hC040_0000, 1'b0);
    chk("R5 normal kept fwdA", fwdA, 32'h0080_0000);
    chk("R10 fwdB", fwdB, 32'hC040_0000);
    // R6 abs of denormal with flush on: no flush
    issue(3'd1, 1'b0, 1'b1, 32'h8000_0005, 32'h0, 1'b0);
    chk("R6 abs denormal", result, 32'h0000_0005);

    // R8 clear, then event and clear together
    issue(3'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1);
    chk("R8 cleared", {31'b0, invSticky}, 32'd0);
    issue(3'd3, 1'b1, 1'b0, 32'h7FC0_0000, 32'h0, 1'b1);
    chk("R8 set wins over clear", {31'b0, invSticky}, 32'd1);
    chk("R3 exc strobe", {30'b0, excStrobe, wrEn}, 32'b10);
    // R4 qNaN does not touch sticky after clear
    issue(3'd0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1);
    issue(3'd4, 1'b1, 1'b0, 32'h7F80_0001, 32'h0, 1'b0);
    chk("R4 sticky untouched", {31'b0, invSticky}, 32'd0);
    chk("R4 no exc", {31'b0, excStrobe}, 32'd0);

    // R11 reset mid-run
    issue(3'd3, 1'b0, 1'b0, 32'h7FC0_0000, 32'h0, 1'b0);
    chk("R8 set again", {31'b0, invSticky}, 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 sticky reset", {31'b0, invSticky}, 32'd0);
    chk("R11 result reset", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end
endmodule